// File: doc/BRIEF.md
# Clock Output Power-Down Gate

This block decides, for each output clock of a clock generator, whether that clock may toggle. Every source clock is produced inside one fast reference clock domain, so the block samples the source levels on `clk_i` and gates them with one run flag per output. A run flag changes only while its source is low. As a result, a gated output can only stop after a falling edge of its source and can only start on a full rising edge.

A single active-low pin has two functions. After reset it is a tristate request: while it is low, every output-enable line is deasserted and the clocks keep running. Once a fixed window has passed, and at the first cycle in which the pin is high, it becomes a power-down request. From then on it can no longer cause tristate. Power-down is accepted only when the synchronized pin has been seen low on two consecutive rising edges of the CPU source clock. While it is accepted, a status line reports the oscillator as off and every output goes low at its own next falling edge. After release, a wake counter keeps the outputs low for a set number of cycles. A static per-output enable bit holds a disabled output low.

Top module: `clk_pd_gate`

## Requirements
- R1: The pin passes through a two-stage synchronizer. Power-down is accepted only after the synchronized pin has been sampled low on two consecutive rising edges of source `CPU_IDX`, so a low pulse that covers at most one such edge has no effect at `osc_off_o`.
- R2: While power-down is accepted, `osc_off_o` is 1 and every `clk_o` bit stays low once it has fallen.
- R3: A `clk_o` bit falls only when its source falls, so every high pulse it shows lasts as long as a full high phase of its source.
- R4: After the pin is sampled high on a CPU rising edge, `osc_off_o` stays 1 and the outputs stay low for `WAKE_CYC` more cycles.
- R5: A stopped output restarts only on a rising edge of its source, never in the middle of a high phase.
- R6: An output whose `out_en_i` bit is 0 is held low. When the bit returns to 1, the output resumes on a clean rising edge.
- R7: During the first `MODE_CYC` cycles after reset, a low pin drives all `oe_o` bits to 0 within 3 cycles and does not start power-down.
- R8: If the pin is still low when the window ends, it keeps its tristate meaning until it goes high. After that it acts only as power-down.
- R9: During reset, `clk_o` is all 0, `osc_off_o` is 0, and `oe_o` follows the tristate state, which is all 1 with the pin high.
- R10: Whenever tristate is not active, all `oe_o` bits are 1, including during power-down and for disabled outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock that samples the source clocks |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_clk_i | input | N_OUT | Ungated source clocks; bit CPU_IDX is the CPU clock |
| out_en_i | input | N_OUT | Static per-output enable, 1 = may toggle |
| pd_tri_ni | input | 1 | Shared active-low tristate / power-down pin |
| clk_o | output | N_OUT | Gated clocks |
| oe_o | output | N_OUT | Output-enable per clock group, 0 = tristate |
| osc_off_o | output | 1 | Oscillator-off status, high in power-down and wake |

## Verification
A run flag that changes while its source is high shows up at once as a high pulse on `clk_o` that is shorter than the source's half period. The bench measures every pulse against each source's known half period. A qualifier count that is wrong sets `osc_off_o` within one CPU period of a short glitch. A wake counter or a pin-function flag that is wrong shows up within tens of cycles: `osc_off_o` clears too early, or `oe_o` drops during power-down.

// File: rtl/clk_pd_pkg.sv
package clk_pd_pkg;
  typedef enum logic {
    PIN_TRI = 1'b0,
    PIN_PD  = 1'b1
  } pin_fn_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[s] <= 1'b1;
        else if (s == 0) ff_q[s] <= d_i;
        else ff_q[s] <= ff_q[(s > 0) ? s-1 : 0];
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/pin_fn_ctl.sv
module pin_fn_ctl
  import clk_pd_pkg::*;
#(
  parameter int MODE_CYC = 200
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    pin_s_i,
  output pin_fn_e fn_o,
  output logic    tri_o
);
  localparam int CW = $clog2(MODE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          done;
  pin_fn_e       fn_q;

  assign done = (cnt_q == CW'(MODE_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      fn_q  <= PIN_TRI;
    end else begin
      if (!done) cnt_q <= cnt_q + 1'b1;
      // a held tristate request defers the switch until release
      if (fn_q == PIN_TRI && done && pin_s_i) fn_q <= PIN_PD;
    end
  end

  assign fn_o  = fn_q;
  assign tri_o = (fn_q == PIN_TRI) && !pin_s_i;

  AST_FN_ONE_WAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fn_q) == PIN_PD) |-> (fn_q == PIN_PD)); // R8
  AST_FN_NEEDS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_q == PIN_PD && $past(fn_q) == PIN_TRI) |-> $past(pin_s_i)); // R8
endmodule

// File: rtl/pd_qual.sv
module pd_qual #(
  parameter int WAKE_CYC = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_clk_i,
  input  logic pin_s_i,
  input  logic arm_i,
  output logic hold_o
);
  localparam int WW = $clog2(WAKE_CYC + 1);

  logic          cpu_q;
  logic          rise;
  logic [1:0]    low_cnt_q;
  logic          asleep;
  logic [WW-1:0] wake_q;

  assign rise   = cpu_clk_i && !cpu_q;
  assign asleep = (low_cnt_q == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_q     <= 1'b0;
      low_cnt_q <= '0;
      wake_q    <= '0;
    end else begin
      cpu_q <= cpu_clk_i;
      if (!arm_i) begin
        low_cnt_q <= '0;
      end else if (rise) begin
        if (pin_s_i) low_cnt_q <= '0;
        else if (!asleep) low_cnt_q <= low_cnt_q + 1'b1;
      end
      if (arm_i && rise && pin_s_i && asleep) wake_q <= WW'(WAKE_CYC);
      else if (wake_q != '0) wake_q <= wake_q - 1'b1;
    end
  end

  assign hold_o = asleep || (wake_q != '0);

  AST_TWO_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asleep) |-> ($past(rise) && !$past(pin_s_i))); // R1
  AST_WAKE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(asleep) |-> hold_o); // R4
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic allow_i,
  output logic clk_o
);
  logic run_q;

  // run flag moves only in the source's low phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else if (!src_i) run_q <= allow_i;
  end

  assign clk_o = src_i && run_q;

  AST_NO_RUNT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_o) |-> !src_i); // R3
  AST_CLEAN_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o) |-> !$past(src_i)); // R5
endmodule

// File: rtl/clk_pd_gate.sv
module clk_pd_gate
  import clk_pd_pkg::*;
#(
  parameter int N_OUT       = 8,
  parameter int CPU_IDX     = 0,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_CYC    = 200,
  parameter int WAKE_CYC    = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_OUT-1:0] src_clk_i,
  input  logic [N_OUT-1:0] out_en_i,
  input  logic             pd_tri_ni,
  output logic [N_OUT-1:0] clk_o,
  output logic [N_OUT-1:0] oe_o,
  output logic             osc_off_o
);
  logic    pin_s;
  logic    tri_act;
  logic    hold;
  pin_fn_e fn;

  pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pd_tri_ni), .q_o(pin_s)
  );

  pin_fn_ctl #(.MODE_CYC(MODE_CYC)) u_fn (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_s_i(pin_s), .fn_o(fn), .tri_o(tri_act)
  );

  pd_qual #(.WAKE_CYC(WAKE_CYC)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .cpu_clk_i(src_clk_i[CPU_IDX]),
    .pin_s_i(pin_s), .arm_i(fn == PIN_PD), .hold_o(hold)
  );

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
      clk_gate_cell u_cell (
        .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_clk_i[i]),
        .allow_i(out_en_i[i] && !hold), .clk_o(clk_o[i])
      );

      AST_PD_STAYS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (osc_off_o && $past(osc_off_o) && !clk_o[i]) |=> (!osc_off_o || !clk_o[i])); // R2
      AST_DIS_STAYS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!out_en_i[i] && !$past(out_en_i[i]) && !clk_o[i]) |=> (out_en_i[i] || !clk_o[i])); // R6
    end
  endgenerate

  assign oe_o      = {N_OUT{!tri_act}};
  assign osc_off_o = hold;

  AST_OE_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(oe_o) == 0) || ($countones(oe_o) == N_OUT)); // R10
  AST_NO_TRI_IN_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_off_o |-> (oe_o != '0)); // R10
endmodule

// File: tb/sim_clk_pd_gate.sv
module sim_clk_pd_gate;
  localparam int CLK_T    = 10;
  localparam int N        = 8;
  localparam int MODE_CYC = 200;
  localparam int WAKE_CYC = 40;
  localparam int HALF [N] = '{2, 3, 4, 5, 2, 3, 6, 7};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src;
  logic [N-1:0] en = 8'hF7;
  logic         pin_n = 1'b1;
  logic [N-1:0] clk_o;
  logic [N-1:0] oe_o;
  logic         osc_off;

  int n_chk = 0;
  int n_fail = 0;
  int runt_fail [N];
  int hi_run [N];
  bit out3_seen_high = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  clk_pd_gate #(.N_OUT(N), .CPU_IDX(0), .SYNC_STAGES(2),
                .MODE_CYC(MODE_CYC), .WAKE_CYC(WAKE_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_clk_i(src), .out_en_i(en),
    .pd_tri_ni(pin_n), .clk_o(clk_o), .oe_o(oe_o), .osc_off_o(osc_off)
  );

  generate
    for (genvar g = 0; g < N; g++) begin : g_src
      logic s = 1'b0;
      int   c = 0;
      always @(negedge clk) begin
        if (c == HALF[g] - 1) begin c <= 0; s <= ~s; end
        else c <= c + 1;
      end
      assign src[g] = s;
    end
  endgenerate

  // pulse-width monitor: every high pulse must span a full source half period (R3, R5)
  initial begin
    for (int i = 0; i < N; i++) begin runt_fail[i] = 0; hi_run[i] = 0; end
  end
  always @(posedge clk) begin
    #1;
    if (clk_o[3]) out3_seen_high = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (clk_o[i]) hi_run[i]++;
      else if (hi_run[i] != 0) begin
        if (hi_run[i] != HALF[i]) runt_fail[i]++;
        hi_run[i] = 0;
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic test_reset;
    tick(2);
    chk(clk_o == '0, "R9", "clk_o in reset", int'(clk_o), 0);
    chk(!osc_off, "R9", "osc_off in reset", int'(osc_off), 0);
    chk(oe_o == '1, "R9", "oe in reset", int'(oe_o), 255);
    rst_n = 1'b1;
  endtask

  task automatic test_tristate_window;
    bit any_off = 1'b0;
    bit ran = 1'b0;
    pin_n = 1'b0;
    tick(3);
    chk(oe_o == '0, "R7", "oe while tristate", int'(oe_o), 0);
    for (int k = 0; k < 30; k++) begin
      tick();
      if (osc_off) any_off = 1'b1;
      if (clk_o[0]) ran = 1'b1;
    end
    chk(!any_off, "R7", "no power-down in tristate window", int'(any_off), 0);
    chk(ran, "R7", "clocks run while tristate", int'(ran), 1);
    tick(MODE_CYC);
    chk(oe_o == '0, "R8", "tristate kept past window", int'(oe_o), 0);
    chk(!osc_off, "R8", "no power-down past window", int'(osc_off), 0);
    pin_n = 1'b1;
    tick(4);
    chk(oe_o == '1, "R10", "oe after tristate release", int'(oe_o), 255);
  endtask

  task automatic test_short_pulse;
    bit any_off = 1'b0;
    tick(5);
    pin_n = 1'b0;
    tick(2);
    pin_n = 1'b1;
    for (int k = 0; k < 20; k++) begin tick(); if (osc_off) any_off = 1'b1; end
    chk(!any_off, "R1", "short low pulse ignored", int'(any_off), 0);
  endtask

  task automatic test_pd_entry;
    bit any_hi = 1'b0;
    pin_n = 1'b0;
    tick(4);
    chk(!osc_off, "R1", "power-down not before two CPU edges", int'(osc_off), 0);
    tick(16);
    chk(osc_off, "R2", "osc_off after qualification", int'(osc_off), 1);
    chk(oe_o == '1, "R10", "pin low in power-down is not tristate", int'(oe_o), 255);
    tick(10);
    for (int k = 0; k < 40; k++) begin tick(); if (clk_o != '0) any_hi = 1'b1; end
    chk(!any_hi, "R2", "all outputs low in power-down", int'(any_hi), 0);
  endtask

  task automatic test_wake;
    bit any_hi = 1'b0;
    bit [N-1:0] seen = '0;
    pin_n = 1'b1;
    for (int k = 0; k < 38; k++) begin tick(); if (clk_o != '0) any_hi = 1'b1; end
    chk(osc_off, "R4", "osc_off held during wake", int'(osc_off), 1);
    chk(!any_hi, "R4", "outputs low during wake", int'(any_hi), 0);
    tick(14);
    chk(!osc_off, "R4", "osc_off clear after wake", int'(osc_off), 0);
    for (int k = 0; k < 20; k++) begin tick(); seen |= clk_o; end
    chk(seen == en, "R5", "enabled outputs restart", int'(seen), int'(en));
  endtask

  task automatic test_disable;
    bit any_hi = 1'b0;
    bit back = 1'b0;
    en[5] = 1'b0;
    tick(10);
    for (int k = 0; k < 30; k++) begin tick(); if (clk_o[5]) any_hi = 1'b1; end
    chk(!any_hi, "R6", "disabled output held low", int'(any_hi), 0);
    chk(oe_o == '1, "R10", "oe unaffected by enable bit", int'(oe_o), 255);
    en[5] = 1'b1;
    for (int k = 0; k < 20; k++) begin tick(); if (clk_o[5]) back = 1'b1; end
    chk(back, "R6", "re-enabled output resumes", int'(back), 1);
  endtask

  initial begin
    #(CLK_T * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_tristate_window();
    test_short_pulse();
    test_pd_entry();
    test_wake();
    test_disable();
    tick(20);
    for (int i = 0; i < N; i++)
      chk(runt_fail[i] == 0, "R3", $sformatf("no runt pulse on output %0d", i), runt_fail[i], 0);
    chk(!out3_seen_high, "R6", "statically disabled output never high", int'(out3_seen_high), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule